// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's word port and a memory that moves whole blocks. Each address splits into a tag, a set index and a word offset. The set index picks one set of two lines. Both lines' tags are compared at once. On a hit, the access is served from the matching line in the cycle it is presented. On a write hit, only the cached line changes, and the line is marked modified.

On a miss, the block picks a victim line in the set. An empty line is taken first. If both lines are full, the line used less recently is taken. A modified victim is first sent back to memory as one block. The missing block is then fetched. A write miss allocates a line: it fetches the block, then merges the new word into it. The processor sees `cpu_ready` low for the whole miss. It must hold its request steady until `cpu_ready` is seen high.

The word offset is 2 bits and the tag is 9 bits. The set index width is a parameter; it can be set as wide as 13 bits. Coherence with other caches is not handled.

Top module: `assoc2_wb_cache`

## Requirements
- R1: Address bit fields. Bits [1:0] are the word within the block. The next `SET_W` bits are the set. The top 9 bits are the tag. `mem_addr` is the block address {tag, set}. Word k of a block occupies bits [32k+31:32k] of the memory data.
- R2: After reset every line is empty. The first access to any block misses and fetches it, with no write-back. `cpu_ready` and `mem_req` are low while idle.
- R3: A read hit asserts `cpu_ready` in the same cycle as `cpu_req`, with the stored word on `cpu_rdata`. It causes no memory transfer.
- R4: Two blocks with the same set and different tags can be held at the same time. Both then hit.
- R5: A read miss fetches the requested block with `mem_we` low. In the cycle after `mem_ack`, `cpu_ready` is high with the requested word.
- R6: A write hit changes only the cached word. It causes no memory transfer, and later reads return the new value.
- R7: A write miss fetches the block and then merges the written word into it. The other words of the block keep their memory values.
- R8: When both lines of a set are valid, the victim is the line not accessed most recently. A hit and a refill both count as accesses.
- R9: An empty line of the set is filled before any valid line is evicted.
- R10: A modified victim is written to memory (`mem_we` high, its own block address and contents) before the refill. A clean victim is never written.
- R11: During a miss, `cpu_ready` stays low. `mem_req`, `mem_we` and `mem_addr` are held until `mem_ack`.
- R12: The cycle after a write-back's `mem_ack`, the refill read request is already on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+SET_W+WORD_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| mem_req | output | 1 | Memory block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | TAG_W+SET_W | Block address {tag, set} |
| mem_wdata | output | DATA_W<<WORD_W | Block being written back |
| mem_ack | input | 1 | One-cycle completion of a memory transfer |
| mem_rdata | input | DATA_W<<WORD_W | Refill block, valid with mem_ack |

## Verification
On a write miss, the refill completion and the merge of the processor's word happen at the same clock edge. The tag install, the modified bit and the recency bit are all set on that edge too. The bench provokes this with write misses into an empty set and into a set whose victim is modified. It judges the result by reading back the written word and an untouched word of the same block as hits. It then forces that line out and checks the written-back block carries the merged word.

// File: rtl/assoc2_pkg.sv
// Package: shared controller state encoding for the two-way cache.
package assoc2_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } cstate_t;
endpackage

// File: rtl/assoc2_way.sv
// Module: one way of the cache. Per set it holds a valid bit, a modified
// bit, a tag and a full data line.
// Assumes: reads are combinational at rd_set. A write installs a valid
// line with the given tag, data and modified flag. Reset clears only
// valid and modified.
module assoc2_way #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 9,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SET_W-1:0]  rd_set,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              wr_dirty
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] valid_q;
    logic [NSETS-1:0] dirty_q;
    logic [TAG_W-1:0]  tag_q  [NSETS];
    logic [LINE_W-1:0] line_q [NSETS];

    // Status bits: cleared by reset, set on install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
            dirty_q[wr_set] <= wr_dirty;
        end
    end

    // Tag and data storage: no reset needed, guarded by valid.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            line_q[wr_set] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_set];
    assign rd_dirty = dirty_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_line  = line_q[rd_set];
endmodule

// File: rtl/assoc2_lru.sv
// Module: one recency bit per set. The bit names the way to evict next.
// Assumes: an update marks used_way as most recent, so the bit takes the
// other way.
module assoc2_lru #(
    parameter int SET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    output logic             lru_way,
    input  logic             upd_en,
    input  logic             used_way
);
    localparam int NSETS = 1 << SET_W;

    logic [NSETS-1:0] lru_q;

    // Recency update on every hit or refill.
    always_ff @(posedge clk) begin
        if (!rst_n)      lru_q <= '0;
        else if (upd_en) lru_q[set_idx] <= ~used_way;
    end

    assign lru_way = lru_q[set_idx];
endmodule

// File: rtl/assoc2_ctrl.sv
// Module: lookup, victim choice and miss sequencer of the cache.
// Assumes: the processor holds cpu_req, cpu_we, cpu_addr and cpu_wdata
// until it sees cpu_ready. Memory answers each request with a one-cycle
// mem_ack, and refill data is valid with that ack.
module assoc2_ctrl
    import assoc2_pkg::*;
#(
    parameter int TAG_W  = 9,
    parameter int SET_W  = 4,
    parameter int WORD_W = 2,
    parameter int DATA_W = 32,
    localparam int ADDR_W = TAG_W + SET_W + WORD_W,
    localparam int LINE_W = DATA_W << WORD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic                         cpu_ready,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+SET_W-1:0]       mem_addr,
    output logic [LINE_W-1:0]            mem_wdata,
    input  logic                         mem_ack,
    input  logic [LINE_W-1:0]            mem_rdata,
    output logic [SET_W-1:0]             lk_set,
    input  logic [1:0]                   way_valid,
    input  logic [1:0]                   way_dirty,
    input  logic [1:0][TAG_W-1:0]        way_tag,
    input  logic [1:0][LINE_W-1:0]       way_line,
    input  logic                         lru_way,
    output logic [1:0]                   wr_en,
    output logic [TAG_W-1:0]             wr_tag,
    output logic [LINE_W-1:0]            wr_line,
    output logic                         wr_dirty,
    output logic                         lru_upd,
    output logic                         lru_used
);
    cstate_t             state_q, state_d;
    logic [ADDR_W-1:0]   req_addr_q;
    logic                req_we_q;
    logic [DATA_W-1:0]   req_wdata_q;
    logic                vict_q;

    logic [ADDR_W-1:0]   cur_addr;
    logic                cur_we;
    logic [DATA_W-1:0]   cur_wdata;
    logic [TAG_W-1:0]    cur_tag;
    logic [SET_W-1:0]    cur_set;
    logic [WORD_W-1:0]   cur_word;
    logic [1:0]          hit_vec;
    logic                hit;
    logic                hit_way;
    logic                victim;
    logic [LINE_W-1:0]   merge_base;
    logic [LINE_W-1:0]   merged;
    logic [LINE_W-1:0]   rd_line;

    // Request source: live port while idle, latched copy during a miss.
    always_comb begin
        if (state_q == ST_IDLE) begin
            cur_addr  = cpu_addr;
            cur_we    = cpu_we;
            cur_wdata = cpu_wdata;
        end else begin
            cur_addr  = req_addr_q;
            cur_we    = req_we_q;
            cur_wdata = req_wdata_q;
        end
    end

    assign cur_word = cur_addr[WORD_W-1:0];
    assign cur_set  = cur_addr[WORD_W +: SET_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign lk_set   = cur_set;

    // Tag compare in both ways of the selected set.
    always_comb begin
        for (int w = 0; w < 2; w++) begin
            hit_vec[w] = way_valid[w] && (way_tag[w] == cur_tag);
        end
    end

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];
    assign victim  = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : lru_way);

    // Word merge into the hit line or into the arriving refill block.
    always_comb begin
        merge_base = (state_q == ST_FILL) ? mem_rdata : way_line[hit_way];
        merged     = merge_base;
        merged[cur_word*DATA_W +: DATA_W] = cur_wdata;
    end

    // Outputs and next state per controller state.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        rd_line   = way_line[hit_way];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {cur_tag, cur_set};
        mem_wdata = way_line[vict_q];
        wr_en     = '0;
        wr_tag    = cur_tag;
        wr_line   = merged;
        wr_dirty  = 1'b0;
        lru_upd   = 1'b0;
        lru_used  = hit_way;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && hit) begin
                    cpu_ready = 1'b1;
                    lru_upd   = 1'b1;
                    if (cur_we) begin
                        wr_en[hit_way] = 1'b1;
                        wr_dirty       = 1'b1;
                    end
                end else if (cpu_req) begin
                    state_d = (way_valid[victim] && way_dirty[victim]) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tag[vict_q], cur_set};
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en[vict_q] = 1'b1;
                    wr_line       = cur_we ? merged : mem_rdata;
                    wr_dirty      = cur_we;
                    lru_upd       = 1'b1;
                    lru_used      = vict_q;
                    state_d       = ST_RESP;
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                rd_line   = way_line[vict_q];
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cpu_rdata = cpu_ready ? rd_line[cur_word*DATA_W +: DATA_W] : '0;

    // State register and miss latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            vict_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req && !hit) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
                vict_q      <= victim;
            end
        end
    end
endmodule

// File: rtl/assoc2_wb_cache.sv
// Module: top of the two-way set-associative write-back cache. It holds
// two way stores, the per-set recency bits and the controller.
// Assumes: a processor that holds its request until ready, and a
// block-wide memory with a one-cycle acknowledge.
module assoc2_wb_cache #(
    parameter int TAG_W  = 9,
    parameter int SET_W  = 4,
    parameter int WORD_W = 2,
    parameter int DATA_W = 32,
    localparam int ADDR_W = TAG_W + SET_W + WORD_W,
    localparam int LINE_W = DATA_W << WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    output logic                   cpu_ready,
    output logic [DATA_W-1:0]      cpu_rdata,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [TAG_W+SET_W-1:0] mem_addr,
    output logic [LINE_W-1:0]      mem_wdata,
    input  logic                   mem_ack,
    input  logic [LINE_W-1:0]      mem_rdata
);
    logic [SET_W-1:0]        lk_set;
    logic [1:0]              way_valid;
    logic [1:0]              way_dirty;
    logic [1:0][TAG_W-1:0]   way_tag;
    logic [1:0][LINE_W-1:0]  way_line;
    logic                    lru_way;
    logic [1:0]              wr_en;
    logic [TAG_W-1:0]        wr_tag;
    logic [LINE_W-1:0]       wr_line;
    logic                    wr_dirty;
    logic                    lru_upd;
    logic                    lru_used;

    // One storage instance per way.
    for (genvar w = 0; w < 2; w++) begin : g_way
        assoc2_way #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .LINE_W(LINE_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_set  (lk_set),
            .rd_valid(way_valid[w]),
            .rd_dirty(way_dirty[w]),
            .rd_tag  (way_tag[w]),
            .rd_line (way_line[w]),
            .wr_en   (wr_en[w]),
            .wr_set  (lk_set),
            .wr_tag  (wr_tag),
            .wr_line (wr_line),
            .wr_dirty(wr_dirty)
        );
    end

    assoc2_lru #(.SET_W(SET_W)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (lk_set),
        .lru_way (lru_way),
        .upd_en  (lru_upd),
        .used_way(lru_used)
    );

    assoc2_ctrl #(
        .TAG_W (TAG_W),
        .SET_W (SET_W),
        .WORD_W(WORD_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .lk_set   (lk_set),
        .way_valid(way_valid),
        .way_dirty(way_dirty),
        .way_tag  (way_tag),
        .way_line (way_line),
        .lru_way  (lru_way),
        .wr_en    (wr_en),
        .wr_tag   (wr_tag),
        .wr_line  (wr_line),
        .wr_dirty (wr_dirty),
        .lru_upd  (lru_upd),
        .lru_used (lru_used)
    );
endmodule

// File: rtl/assoc2_wb_checker.sv
// Module: port-level protocol checks for assoc2_wb_cache, attached by bind.
// Assumes: the processor holds its request stable until cpu_ready.
module assoc2_wb_checker #(
    parameter int TAG_W  = 9,
    parameter int SET_W  = 4,
    parameter int WORD_W = 2,
    localparam int ADDR_W = TAG_W + SET_W + WORD_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   cpu_ready,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [TAG_W+SET_W-1:0] mem_addr,
    input logic                   mem_ack
);
    // R11: the processor is stalled while memory is busy.
    a_r11_stall_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R11: the request is held until it is acknowledged.
    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: the refill follows a write-back at once.
    a_r12_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R5: a completed refill is answered next cycle.
    a_r5_resp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> cpu_ready);

    // R5: the refill targets the requested block.
    a_r5_fill_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr == cpu_addr[ADDR_W-1:WORD_W]));

    // R1: every block transfer belongs to the requested set.
    a_r1_set_field: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[SET_W-1:0] == cpu_addr[WORD_W +: SET_W]));

    // R10: the written-back block is never the one that missed.
    a_r10_wb_other_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[TAG_W+SET_W-1:SET_W] != cpu_addr[ADDR_W-1 -: TAG_W]));
endmodule

bind assoc2_wb_cache assoc2_wb_checker #(
    .TAG_W (TAG_W),
    .SET_W (SET_W),
    .WORD_W(WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/test_assoc2_wb_cache.sv
// Bench: directed scenarios against a block memory model and a word-level
// reference of the processor's view of memory.
module test_assoc2_wb_cache;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W  = 9;
    localparam int SET_W  = 4;
    localparam int WORD_W = 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = TAG_W + SET_W + WORD_W;
    localparam int BADDR_W = TAG_W + SET_W;
    localparam int LINE_W = DATA_W << WORD_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cpu_req = 1'b0;
    logic                cpu_we = 1'b0;
    logic [ADDR_W-1:0]   cpu_addr = '0;
    logic [DATA_W-1:0]   cpu_wdata = '0;
    logic                cpu_ready;
    logic [DATA_W-1:0]   cpu_rdata;
    logic                mem_req;
    logic                mem_we;
    logic [BADDR_W-1:0]  mem_addr;
    logic [LINE_W-1:0]   mem_wdata;
    logic                mem_ack = 1'b0;
    logic [LINE_W-1:0]   mem_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_wb = 0;
    int n_rf = 0;
    logic [1:0] ops = 2'b00;
    logic [BADDR_W-1:0] wb_addr = '0;
    logic [LINE_W-1:0]  wb_data = '0;
    logic [LINE_W-1:0]  bmem [int];
    logic [DATA_W-1:0]  refm [int];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc2_wb_cache #(
        .TAG_W(TAG_W), .SET_W(SET_W), .WORD_W(WORD_W), .DATA_W(DATA_W)
    ) i_assoc2_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return 32'hC0DE_0000 ^ 32'(a);
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int w);
        return {t[TAG_W-1:0], s[SET_W-1:0], w[WORD_W-1:0]};
    endfunction

    function automatic logic [LINE_W-1:0] blk(input logic [BADDR_W-1:0] b);
        logic [LINE_W-1:0] r;
        if (bmem.exists(int'(b))) return bmem[int'(b)];
        for (int i = 0; i < (1 << WORD_W); i++) r[i*DATA_W +: DATA_W] = pat({b, i[WORD_W-1:0]});
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] expect_word(input logic [ADDR_W-1:0] a);
        if (refm.exists(int'(a))) return refm[int'(a)];
        return pat(a);
    endfunction

    // Block memory model: one-cycle acknowledge, counts transfers.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                bmem[int'(mem_addr)] = mem_wdata;
                wb_addr = mem_addr;
                wb_data = mem_wdata;
                n_wb++;
                ops = {ops[0], 1'b1};
            end else begin
                mem_rdata = blk(mem_addr);
                n_rf++;
                ops = {ops[0], 1'b0};
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          output logic [DATA_W-1:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        if (cyc >= 200) check(1'b0, "R11 hang", 128'(cyc), 128'(0));
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) refm[int'(a)] = wd;
    endtask

    // Read with data check and expected transfer deltas.
    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input int d_rf, input int d_wb);
        logic [DATA_W-1:0] rd;
        int cyc, rf0, wb0;
        logic [DATA_W-1:0] exp;
        rf0 = n_rf; wb0 = n_wb;
        exp = expect_word(a);
        access(1'b0, a, '0, rd, cyc);
        check(rd == exp, {req, " data"}, 128'(rd), 128'(exp));
        check(n_rf - rf0 == d_rf, {req, " refills"}, 128'(n_rf - rf0), 128'(d_rf));
        check(n_wb - wb0 == d_wb, {req, " writebacks"}, 128'(n_wb - wb0), 128'(d_wb));
        if (d_rf == 0) check(cyc == 0, {req, " hit latency"}, 128'(cyc), 128'(0));
        else           check(cyc > 0, {req, " miss stalls (R11)"}, 128'(cyc), 128'(1));
    endtask

    task automatic wr_chk(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input int d_rf, input int d_wb);
        logic [DATA_W-1:0] rd;
        int cyc, rf0, wb0;
        rf0 = n_rf; wb0 = n_wb;
        access(1'b1, a, d, rd, cyc);
        check(n_rf - rf0 == d_rf, {req, " refills"}, 128'(n_rf - rf0), 128'(d_rf));
        check(n_wb - wb0 == d_wb, {req, " writebacks"}, 128'(n_wb - wb0), 128'(d_wb));
        if (d_rf == 0) check(cyc == 0, {req, " hit latency"}, 128'(cyc), 128'(0));
    endtask

    task automatic t_reset;
        #1;
        check(cpu_ready == 1'b0, "R2 ready low in reset idle", 128'(cpu_ready), 128'(0));
        check(mem_req == 1'b0, "R2 mem_req low in reset idle", 128'(mem_req), 128'(0));
        rd_chk("R2 R5 cold read miss", mk(1, 3, 2), 1, 0);
    endtask

    task automatic t_read_hit;
        rd_chk("R3 R1 same block other word", mk(1, 3, 0), 0, 0);
    endtask

    task automatic t_two_ways;
        rd_chk("R9 fill empty way", mk(2, 3, 0), 1, 0);
        rd_chk("R4 first block kept", mk(1, 3, 1), 0, 0);
        rd_chk("R4 second block hits", mk(2, 3, 3), 0, 0);
    endtask

    task automatic t_lru;
        rd_chk("R8 third tag evicts lru", mk(3, 3, 0), 1, 0);
        rd_chk("R8 recent block kept", mk(2, 3, 0), 0, 0);
        rd_chk("R8 lru block was evicted", mk(1, 3, 0), 1, 0);
    endtask

    task automatic t_write_hit;
        wr_chk("R6 write hit", mk(2, 3, 1), 32'hDEAD_BEEF, 0, 0);
        rd_chk("R6 read written word", mk(2, 3, 1), 0, 0);
    endtask

    task automatic t_dirty_evict;
        rd_chk("R8 touch clean block", mk(1, 3, 2), 0, 0);
        rd_chk("R10 dirty victim miss", mk(4, 3, 0), 1, 1);
        check(wb_addr == {9'(2), 4'(3)}, "R10 writeback address", 128'(wb_addr), 128'({9'(2), 4'(3)}));
        check(wb_data[DATA_W +: DATA_W] == 32'hDEAD_BEEF, "R10 writeback data",
              128'(wb_data[DATA_W +: DATA_W]), 128'(32'hDEAD_BEEF));
        check(ops == 2'b10, "R12 writeback before refill", 128'(ops), 128'(2'b10));
        rd_chk("R10 clean victim not written", mk(2, 3, 1), 1, 0);
    endtask

    task automatic t_write_miss;
        wr_chk("R7 write miss allocates", mk(5, 7, 3), 32'h1234_5678, 1, 0);
        rd_chk("R7 merged word", mk(5, 7, 3), 0, 0);
        rd_chk("R7 other word from memory", mk(5, 7, 0), 0, 0);
        wr_chk("R7 R9 write miss empty way", mk(6, 7, 1), 32'hA5A5_0001, 1, 0);
        wr_chk("R7 R10 write miss dirty victim", mk(7, 7, 2), 32'h0F0F_0002, 1, 1);
        check(wb_addr == {9'(5), 4'(7)}, "R10 merged line writeback address", 128'(wb_addr), 128'({9'(5), 4'(7)}));
        check(wb_data[3*DATA_W +: DATA_W] == 32'h1234_5678, "R7 merged word written back",
              128'(wb_data[3*DATA_W +: DATA_W]), 128'(32'h1234_5678));
        rd_chk("R7 refetch merged line", mk(5, 7, 3), 1, 1);
    endtask

    task automatic t_set_field;
        rd_chk("R1 same tag other set misses", mk(2, 4, 1), 1, 0);
        rd_chk("R1 original set still hits", mk(2, 3, 1), 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_read_hit;
        t_two_ways;
        t_lru;
        t_write_hit;
        t_dirty_evict;
        t_write_miss;
        t_set_field;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule